// File: doc/BRIEF.md
# Translation Lookaside Buffer with Flush-All

This block keeps a small, fully associative set of recent Sv39 page translations in front of a hardware page table walker. A requester presents a 39-bit virtual address. The upper 27 bits, which are the three 9-bit level indices joined together, are compared against every valid entry at once. On a hit, the block answers in the same cycle. It returns the 44-bit physical page number joined with the untouched 12-bit page offset, together with the permission and status flags stored for that page.

On a miss, the block holds the requester off and issues a walk request carrying the page number. It installs the walker's answer into an entry. The held request then hits on the following cycle. A walk that reports a fault is passed back to the requester and is never cached.

A single flush command invalidates every entry, so that stale mappings are not served after the tables change. A walk that is still in flight when a flush arrives has its result discarded.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, and while no request is present `req_ready`, `resp_valid` and `walk_req_valid` are all 0.
- R2: The response address is the cached 44-bit physical page number in bits 55..12 and the request's bits 11..0 copied unchanged into bits 11..0.
- R3: The tag is the full 27-bit page number (request bits 38..12). Addresses that differ in any of those bits, including only bit 38, are cached as separate translations.
- R4: On a miss, `req_ready` stays 0 and `walk_req_valid` rises in the next cycle with `walk_vpn` equal to the request's page number. It stays high with `walk_vpn` stable until `walk_done`. After the refill, the held request is answered in the following cycle.
- R5: A request whose page number matches a valid entry gets `req_ready` and `resp_valid` in the same cycle, with no walk issued.
- R6: A `flush` pulse invalidates every entry, so every later lookup misses until it is refilled. A lookup in the flush cycle itself is not answered.
- R7: A walk that returns `walk_fault`=1 is answered to the waiting request with `resp_fault`=1, an address of 0 and flags of 0. It is not installed, so the same page misses again.
- R8: If `flush` is asserted while a walk is outstanding, or in the same cycle as `walk_done`, the walk result is not installed, and the held request starts a new walk.
- R9: A refill goes into the lowest-numbered invalid entry when one exists. When all entries are valid, it replaces entries in round-robin order starting at entry 0.
- R10: The 8 flag bits returned with a hit are the flags that the walker supplied for that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 39 | Virtual address to translate |
| req_ready | output | 1 | Request accepted this cycle |
| resp_valid | output | 1 | Response valid (with req_ready) |
| resp_paddr | output | 56 | Translated physical address |
| resp_flags | output | 8 | Flags of the mapping |
| resp_fault | output | 1 | Walk reported a fault |
| walk_req_valid | output | 1 | Walk requested |
| walk_vpn | output | 27 | Page number to walk |
| walk_done | input | 1 | Walker result present |
| walk_ppn | input | 44 | Physical page number from walker |
| walk_flags | input | 8 | Flags from walker |
| walk_fault | input | 1 | Walker found no valid mapping |

## Verification
The hardest situation to reach is a flush landing inside a walk, between the request and the walker's answer. The bench's walker model gives each walk a programmable latency. A concurrent stimulus thread pulses `flush` a fixed number of cycles into a long walk. The bench then expects the same held lookup to cost two walks. Round-robin eviction is also reached only after every entry has been filled. The bench fills all eight entries and then confirms which of the old pages miss again.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 44,
  parameter int OFF_W   = 12,
  parameter int FLAG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic [PPN_W+OFF_W-1:0]   resp_paddr,
  output logic [FLAG_W-1:0]        resp_flags,
  output logic                     resp_fault,
  output logic                     walk_req_valid,
  output logic [VPN_W-1:0]         walk_vpn,
  input  logic                     walk_done,
  input  logic [PPN_W-1:0]         walk_ppn,
  input  logic [FLAG_W-1:0]        walk_flags,
  input  logic                     walk_fault
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [FLAG_W-1:0]  flg_q [ENTRIES];
  logic               busy, kill, fpend;
  logic [VPN_W-1:0]   wvpn;
  logic [IW-1:0]      rr, victim;
  logic [PPN_W-1:0]   hit_ppn;
  logic [FLAG_W-1:0]  hit_flg;
  logic               hit, fhit, start, install, wend;

  wire [VPN_W-1:0] req_vpn = req_vaddr[OFF_W +: VPN_W];
  wire [OFF_W-1:0] req_off = req_vaddr[OFF_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tag_q[i] == req_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    hit_flg = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_flg = hit_flg | flg_q[i];
      end
  end

  always_comb begin
    victim = rr;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) victim = IW'(i);
  end

  assign hit     = req_valid && (|match) && !flush;
  assign fhit    = req_valid && fpend && (req_vpn == wvpn) && !flush;
  assign start   = req_valid && !hit && !fhit && !busy;
  assign wend    = busy && walk_done;
  assign install = wend && !kill && !flush && !walk_fault;

  assign req_ready      = hit || fhit;
  assign resp_valid     = hit || fhit;
  assign resp_fault     = fhit;
  assign resp_paddr     = fhit ? '0 : {hit_ppn, req_off};
  assign resp_flags     = fhit ? '0 : hit_flg;
  assign walk_req_valid = busy;
  assign walk_vpn       = wvpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      rr    <= '0;
      busy  <= 1'b0;
      kill  <= 1'b0;
      fpend <= 1'b0;
      wvpn  <= '0;
    end else begin
      if (flush) valid <= '0;
      else if (install) valid[victim] <= 1'b1;

      if (install && (&valid))
        rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + 1'b1;

      if (start) begin
        busy <= 1'b1;
        kill <= 1'b0;
        wvpn <= req_vpn;
      end else if (wend) begin
        busy <= 1'b0;
        kill <= 1'b0;
      end else if (busy && flush) begin
        kill <= 1'b1;
      end

      if (flush) fpend <= 1'b0;
      else if (wend && walk_fault && !kill) fpend <= 1'b1;
      else if (fhit || start) fpend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[victim] <= wvpn;
      ppn_q[victim] <= walk_ppn;
      flg_q[victim] <= walk_flags;
    end
  end

  a_r4_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_done) |=> (walk_req_valid && $stable(walk_vpn)));

  a_r4_miss_starts_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !walk_req_valid) |=> walk_req_valid);

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  a_r7_fault_not_cached: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault && !flush) |=> (valid == $past(valid)));

  a_r8_killed_walk_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kill && walk_done && !flush) |=> (valid == $past(valid)));
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  logic        clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [38:0] req_vaddr = '0;
  logic        req_ready, resp_valid, resp_fault, walk_req_valid;
  logic [55:0] resp_paddr;
  logic [7:0]  resp_flags;
  logic [26:0] walk_vpn;
  logic        walk_done = 0, walk_fault = 0;
  logic [43:0] walk_ppn = '0;
  logic [7:0]  walk_flags = '0;

  xlate_cache uut (.*);

  always #5 clk = ~clk;

  int checks = 0, bad = 0, walks = 0, wlat = 2;
  logic [26:0] last_vpn;
  bit fault_pg [logic [26:0]];
  logic [55:0] q_pa[$];
  logic [7:0]  q_fl[$];
  logic        q_ft[$];

  function automatic logic [43:0] ppn_of(logic [26:0] v);
    return {v ^ 27'h5A5A5A5, 17'h1F0F0};
  endfunction
  function automatic logic [7:0] flg_of(logic [26:0] v);
    return v[7:0] | 8'h01;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // walker model
  initial forever begin
    @(negedge clk);
    if (walk_req_valid) begin
      logic [26:0] v;
      v = walk_vpn;
      last_vpn = v;
      repeat (wlat) @(negedge clk);
      walks++;
      walk_done  = 1;
      walk_ppn   = ppn_of(v);
      walk_flags = flg_of(v);
      walk_fault = fault_pg.exists(v);
      @(negedge clk);
      walk_done = 0;
      walk_fault = 0;
    end
  end

  // monitor: compare accepted responses with expected queue
  initial forever begin
    @(negedge clk);
    #3;
    if (req_valid && req_ready) begin
      if (q_pa.size() == 0) chk(0, "R5", "unexpected response", 1, 0);
      else begin
        logic [55:0] pa; logic [7:0] fl; logic ft;
        pa = q_pa.pop_front(); fl = q_fl.pop_front(); ft = q_ft.pop_front();
        chk(resp_valid, "R5", "resp_valid", resp_valid, 1);
        chk(resp_paddr == pa, "R2", "paddr", resp_paddr, pa);
        chk(resp_flags == fl, "R10", "flags", resp_flags, fl);
        chk(resp_fault == ft, "R7", "fault", resp_fault, ft);
      end
    end
  end

  task automatic lookup(logic [38:0] va, int exp_walks, string req);
    logic [26:0] v;
    int w0, waited;
    bit done;
    v = va[38:12];
    if (fault_pg.exists(v)) begin
      q_pa.push_back('0); q_fl.push_back('0); q_ft.push_back(1'b1);
    end else begin
      q_pa.push_back({ppn_of(v), va[11:0]}); q_fl.push_back(flg_of(v)); q_ft.push_back(1'b0);
    end
    w0 = walks;
    waited = 0;
    done = 0;
    @(negedge clk);
    req_valid = 1;
    req_vaddr = va;
    while (!done) begin
      #3;
      if (req_ready) done = 1;
      else begin
        waited++;
        if (waited > 60) begin chk(0, req, "stuck", waited, 0); done = 1; end
        else @(negedge clk);
      end
    end
    chk(walks - w0 == exp_walks, req, "walk count", walks - w0, exp_walks);
    if (exp_walks == 0) chk(waited == 0, req, "hit wait cycles", waited, 0);
    else begin
      chk(waited > 0, "R4", "ready low during miss", waited, 1);
      chk(last_vpn == v, "R4", "walk_vpn", last_vpn, v);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic flush_pulse();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(!req_ready && !resp_valid && !walk_req_valid, "R1", "idle outputs",
        {req_ready, resp_valid, walk_req_valid}, 0);

    // R2 R3 R4 R5: two pages differing only in bit 38
    lookup({1'b0, 26'h0000001, 12'h5AB}, 1, "R4");
    lookup({1'b1, 26'h0000001, 12'h123}, 1, "R3");
    lookup({1'b0, 26'h0000001, 12'hFFF}, 0, "R5");
    lookup({1'b1, 26'h0000001, 12'h000}, 0, "R3");

    // R7: faulting walk forwarded, not cached
    fault_pg[27'h0000777] = 1;
    lookup({27'h0000777, 12'h010}, 1, "R7");
    lookup({27'h0000777, 12'h010}, 1, "R7");

    // R6: flush invalidates everything
    flush_pulse();
    lookup({1'b0, 26'h0000001, 12'h5AB}, 1, "R6");
    lookup({1'b0, 26'h0000001, 12'h5AB}, 0, "R6");

    // R8: flush while a walk is outstanding
    wlat = 6;
    fork
      lookup({27'h0000ABC, 12'h044}, 2, "R8");
      begin repeat (3) @(negedge clk); flush = 1; @(negedge clk); flush = 0; end
    join
    lookup({27'h0000ABC, 12'h048}, 0, "R8");
    wlat = 1;

    // R9: fill all entries then round-robin eviction
    flush_pulse();
    for (int k = 0; k < 8; k++) lookup({27'(100 + k), 12'h0}, 1, "R9");
    for (int k = 0; k < 8; k++) lookup({27'(100 + k), 12'h1}, 0, "R9");
    lookup({27'd108, 12'h2}, 1, "R9");
    lookup({27'd101, 12'h3}, 0, "R9");
    lookup({27'd100, 12'h4}, 1, "R9");
    lookup({27'd102, 12'h5}, 0, "R9");
    lookup({27'd101, 12'h6}, 1, "R9");
    lookup({27'd108, 12'h7}, 0, "R9");

    repeat (3) @(negedge clk);
    chk(q_pa.size() == 0, "R5", "pending responses", q_pa.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule